// File: doc/BRIEF.md
# Programmable Chip-Select Unit with Zero-Wait Termination

This block decodes the upper address bits of an external bus cycle against a small bank of programmable channels. Each matching channel drives its own active-low select line, gated by the strobe the channel is set to follow. The unit can also end the bus cycle itself by driving a two-bit active-low acknowledge pair. It does so either in the first system-clock edge of the cycle, which is the zero-wait mode, or after a programmed number of wait states. A channel can instead leave termination to an acknowledge that comes from the addressed device.

All state is clocked by the system clock, and the cycle is marked by the address strobe. An internally generated acknowledge is therefore synchronous to that clock and needs no synchronizer. Software loads one channel per write through a narrow configuration port. After reset every channel is disabled.

Top module: `chip_select_unit`

## Requirements
- R1: After reset all channels are disabled, every `cs_n` bit is 1 and `dsack_n` is 2'b11.
- R2: A channel matches when it is enabled and `addr_hi` equals its base, ignoring the `blk` lowest bits of the eight compared bits (blk = 0 compares all eight, blk = 4 ignores the low four).
- R3: The strobe field gates only the select line. With strb_ds = 0 the channel's `cs_n` is low while `as_n` is low. With strb_ds = 1 it is low only while both `as_n` and `ds_n` are low. Matching and acknowledge timing do not depend on this field.
- R4: Ack code 4'b1110 is zero-wait. `dsack_n` becomes 2'b00 after the first rising clock edge that samples `as_n` low.
- R5: Ack codes 0 to 13 insert that many wait states. `dsack_n` becomes 2'b00 after rising edge number code+1, counting from 0 at the first edge that samples `as_n` low.
- R6: Ack code 4'b1111 leaves termination external, and `dsack_n` stays 2'b11. Every matching channel asserts its select line. The acknowledge timing comes from the lowest-numbered matching channel whose code is not 4'b1111.
- R7: When `as_n` goes high, `dsack_n` returns to 2'b11 and all `cs_n` bits return to 1 in the same cycle, without waiting for a clock edge.
- R8: A disabled channel, or an address that matches no channel, produces no select and no acknowledge.
- R9: Function code 3'b111 (CPU space) matches no channel.
- R10: The rwq field sets the allowed direction: bit 0 allows reads (`rd` = 1) and bit 1 allows writes. A cycle in a direction that is not allowed produces neither select nor acknowledge on that channel.
- R11: With `cfg_we` high at a rising edge, channel `cfg_ch` loads `cfg_wdata`, laid out from MSB to LSB as en[18], rwq[17:16], strb_ds[15], ack[14:11], blk[10:8], base[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_ch | input | CHW | Channel index to load |
| cfg_wdata | input | 19 | Channel configuration word |
| addr_hi | input | 8 | Upper address bits compared against channel bases |
| rd | input | 1 | 1 for a read cycle, 0 for a write cycle |
| fc | input | 3 | Function code, valid while `as_n` is low |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| cs_n | output | NCH | Per-channel chip selects, active low |
| dsack_n | output | 2 | Acknowledge pair, active low |

## Verification
The bench goes after these corner cases:
- **Zero-wait against zero wait states.** A design that merges the two would acknowledge one edge late, or one edge early.
- **Overlapping channels, one external and one internal.** A design that lets the external channel win would never end the cycle.
- **Data-strobe-qualified channel on a cycle with no data strobe.** The select must stay off, but a wrong design would assert it or also drop the acknowledge.
- **Ends of the range.** This covers block-size masking at the edge of a block, wrong-direction and CPU-space cycles, and the longest wait of 13. An off-by-one counter shows up on that longest wait.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int CMPW = 8;
  localparam logic [3:0] ACK_FAST = 4'b1110;
  localparam logic [3:0] ACK_EXT  = 4'b1111;

  typedef struct packed {
    logic            en;
    logic [1:0]      rwq;
    logic            strb_ds;
    logic [3:0]      ack;
    logic [2:0]      blk;
    logic [CMPW-1:0] base;
  } csu_cfg_t;

  function automatic logic [CMPW-1:0] blk_mask(input logic [2:0] blk);
    return ~((CMPW'(1) << blk) - CMPW'(1));
  endfunction

  function automatic logic dir_ok(input logic [1:0] rwq, input logic rd);
    return rd ? rwq[0] : rwq[1];
  endfunction
endpackage

// File: rtl/csu_cfg_bank.sv
module csu_cfg_bank
  import csu_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [CHW-1:0]       ch,
  input  csu_cfg_t             wdata,
  output csu_cfg_t [NCH-1:0]   cfg
);
  for (genvar i = 0; i < NCH; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cfg[i] <= '0;
      else if (we && ch == CHW'(i))  cfg[i] <= wdata;
    end
  end
endmodule

// File: rtl/csu_match.sv
module csu_match
  import csu_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [CMPW-1:0]      addr_hi,
  input  logic                 rd,
  input  logic [2:0]           fc,
  input  csu_cfg_t [NCH-1:0]   cfg,
  output logic [NCH-1:0]       match
);
  logic cpu_space;
  assign cpu_space = (fc == 3'b111);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CMPW-1:0] msk;
    assign msk = blk_mask(cfg[i].blk);
    assign match[i] = cfg[i].en && !cpu_space && dir_ok(cfg[i].rwq, rd)
                      && ((addr_hi & msk) == (cfg[i].base & msk));
  end

  always_comb begin
    if (fc == 3'b111) a_r9_cpu_space_blocks: assert (match == '0);
  end
endmodule

// File: rtl/csu_ack_timer.sv
module csu_ack_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       as_act,
  input  logic       start,
  input  logic       go,
  input  logic       fast,
  input  logic [3:0] wait_n,
  output logic       ack
);
  logic       run;
  logic [3:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0;
      run <= 1'b0;
      cnt <= '0;
    end else if (!as_act) begin
      ack <= 1'b0;
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      if (go && fast) begin
        ack <= 1'b1;
      end else if (go) begin
        run <= 1'b1;
        cnt <= wait_n;
      end
    end else if (run) begin
      if (cnt == '0) begin
        ack <= 1'b1;
        run <= 1'b0;
      end else begin
        cnt <= cnt - 4'd1;
      end
    end
  end

  a_r4_fast_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (start && go && fast && as_act) |=> ack);
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= 4'd13));
  a_r7_clear_on_negate: assert property (@(posedge clk) disable iff (!rst_n)
    !as_act |=> !ack);
endmodule

// File: rtl/chip_select_unit.sv
module chip_select_unit
  import csu_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CHW-1:0]       cfg_ch,
  input  logic [18:0]          cfg_wdata,
  input  logic [CMPW-1:0]      addr_hi,
  input  logic                 rd,
  input  logic [2:0]           fc,
  input  logic                 as_n,
  input  logic                 ds_n,
  output logic [NCH-1:0]       cs_n,
  output logic [1:0]           dsack_n
);
  csu_cfg_t [NCH-1:0] cfg;
  logic [NCH-1:0]     match;
  logic [NCH-1:0]     sel_q;
  logic               as_act, ds_act, as_prev, start;
  logic               go, fast, ack;
  logic [3:0]         wait_n;

  assign as_act = !as_n;
  assign ds_act = !ds_n;
  assign start  = as_act && !as_prev;

  csu_cfg_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .ch(cfg_ch),
    .wdata(csu_cfg_t'(cfg_wdata)), .cfg(cfg)
  );

  csu_match #(.NCH(NCH)) u_match (
    .addr_hi(addr_hi), .rd(rd), .fc(fc), .cfg(cfg), .match(match)
  );

  // lowest-numbered matching channel with internal termination sets timing
  always_comb begin
    go     = 1'b0;
    fast   = 1'b0;
    wait_n = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (match[i] && cfg[i].ack != ACK_EXT) begin
        go     = 1'b1;
        fast   = (cfg[i].ack == ACK_FAST);
        wait_n = cfg[i].ack;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_prev <= 1'b0;
      sel_q   <= '0;
    end else begin
      as_prev <= as_act;
      if (!as_act)    sel_q <= '0;
      else if (start) sel_q <= match;
    end
  end

  csu_ack_timer u_timer (
    .clk(clk), .rst_n(rst_n), .as_act(as_act), .start(start),
    .go(go), .fast(fast), .wait_n(wait_n), .ack(ack)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_cs
    assign cs_n[i] = !(sel_q[i] && as_act && (!cfg[i].strb_ds || ds_act));
  end

  assign dsack_n = (ack && as_act) ? 2'b00 : 2'b11;

  a_r8_ack_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (sel_q != '0));
  a_r6_no_select_outside_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !as_prev |-> (sel_q == '0));
endmodule

// File: tb/chip_select_unit_tb.sv
module chip_select_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NONE = 31;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [18:0] cfg_wdata = '0;
  logic [7:0] addr_hi = '0;
  logic       rd = 1'b1;
  logic [2:0] fc = 3'd5;
  logic       as_n = 1'b1;
  logic       ds_n = 1'b1;
  logic [3:0] cs_n;
  logic [1:0] dsack_n;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chip_select_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_wdata(cfg_wdata), .addr_hi(addr_hi), .rd(rd), .fc(fc),
    .as_n(as_n), .ds_n(ds_n), .cs_n(cs_n), .dsack_n(dsack_n)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=%0d exp<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {addr, rd, fc, ds, exp cs_n, exp ack edge}
  localparam logic [21:0] VEC [11] = '{
    {8'h10, 1'b1, 3'd5, 1'b1, 4'b1010, 5'd0},  // R4 R6 overlap ch0 fast, ch2 ext
    {8'h10, 1'b0, 3'd5, 1'b0, 4'b1010, 5'd0},  // R3 R4 fast write, AS-qualified
    {8'h23, 1'b1, 3'd5, 1'b1, 4'b1101, 5'd3},  // R2 R5 block match, 2 waits
    {8'h23, 1'b1, 3'd5, 1'b0, 4'b1111, 5'd3},  // R3 no data strobe, ack kept
    {8'h23, 1'b0, 3'd5, 1'b0, 4'b1111, 5'd31}, // R10 read-only channel on write
    {8'h41, 1'b0, 3'd5, 1'b0, 4'b0111, 5'd1},  // R5 zero waits, blk=1
    {8'h41, 1'b1, 3'd5, 1'b1, 4'b1111, 5'd31}, // R10 write-only channel on read
    {8'h42, 1'b0, 3'd5, 1'b0, 4'b1111, 5'd31}, // R2 R8 just outside block
    {8'h10, 1'b1, 3'd7, 1'b1, 4'b1111, 5'd31}, // R9 CPU space
    {8'h2F, 1'b1, 3'd6, 1'b1, 4'b1101, 5'd3},  // R2 top of block
    {8'h30, 1'b1, 3'd5, 1'b1, 4'b1111, 5'd31}  // R8 unmapped
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] mk(input logic en, input logic [1:0] rwq,
      input logic sds, input logic [3:0] ack, input logic [2:0] blk,
      input logic [7:0] base);
    return {en, rwq, sds, ack, blk, base};
  endfunction

  task automatic load(input int ch, input logic [18:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_ch = 2'(ch);
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_cycle(input logic [7:0] a, input logic r, input logic [2:0] f,
      input logic use_ds, input logic [3:0] exp_cs, input int exp_k, input string tag);
    int first_k = NONE;
    logic [3:0] cs_seen = 4'hF;
    @(negedge clk);
    addr_hi = a; rd = r; fc = f;
    as_n = 1'b0;
    ds_n = !use_ds;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k == 0) cs_seen = cs_n;
      if (first_k == NONE && dsack_n == 2'b00) first_k = k;
    end
    check({tag, " select"}, cs_seen, exp_cs);
    check({tag, " ack edge"}, first_k, exp_k);
    as_n = 1'b1;
    ds_n = 1'b1;
    #1;
    check("R7 ack released on strobe negate", dsack_n, 2'b11);
    check("R7 selects released on strobe negate", cs_n, 4'hF);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*2 + 1);
    check("R1 selects in reset", cs_n, 4'hF);
    check("R1 ack in reset", dsack_n, 2'b11);
    rst_n = 1'b1;
    // R1: disabled channels after reset, cycle to a later-used address
    run_cycle(8'h10, 1'b1, 3'd5, 1'b1, 4'b1111, NONE, "R1 idle after reset");

    // R11: program channels through the write port
    load(0, mk(1'b1, 2'b11, 1'b0, 4'b1110, 3'd0, 8'h10));
    load(1, mk(1'b1, 2'b01, 1'b1, 4'd2,    3'd4, 8'h20));
    load(2, mk(1'b1, 2'b11, 1'b0, 4'b1111, 3'd0, 8'h10));
    load(3, mk(1'b1, 2'b10, 1'b0, 4'd0,    3'd1, 8'h40));

    for (int i = 0; i < 11; i++) begin
      run_cycle(VEC[i][21:14], VEC[i][13], VEC[i][12:10], VEC[i][9],
                VEC[i][8:5], int'(VEC[i][4:0]), $sformatf("R2/R3 vector %0d", i));
    end

    // R6 R8: ch0 disabled, only external ch2 matches
    load(0, mk(1'b0, 2'b11, 1'b0, 4'b1110, 3'd0, 8'h10));
    run_cycle(8'h10, 1'b1, 3'd5, 1'b1, 4'b1011, NONE, "R6 external only");

    // R5 R11: longest wait
    load(3, mk(1'b1, 2'b11, 1'b0, 4'd13, 3'd0, 8'h40));
    run_cycle(8'h40, 1'b0, 3'd5, 1'b0, 4'b0111, 14, "R5 thirteen waits");

    // R6: two internal channels overlap, lower index wins
    load(1, mk(1'b1, 2'b11, 1'b0, 4'd5, 3'd0, 8'h40));
    run_cycle(8'h40, 1'b1, 3'd5, 1'b1, 4'b0101, 6, "R6 priority");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule